// File: doc/BRIEF.md
# Half-Cycle Gated Five-Switch Buck-Boost Inverter Modulator

This block drives the five gate lines of a single-stage, common-ground buck-boost inverter. At each wrap of its up-counting carrier it samples a signed output-voltage reference (a sign bit and an unsigned magnitude) and an unsigned DC input-voltage measurement. From these it selects one of three operating intervals:

- **buck**: positive reference, magnitude not above the input;
- **boost**: positive reference, magnitude above the input;
- **negative**: negative reference.

A restoring divider then works out, as a 16-bit fraction, the duty ratio of the single switch that chops in that interval. All other switches are held at static levels for the whole interval.

The sample taken at one wrap takes effect at the next wrap. Interval and duty are therefore constant across every carrier period, and the divider has a whole period to finish. The chopping gate is high from count 0 while the carrier count is below the duty scaled by the period length. The duty is capped below unity so that the chopping switch is always off for part of every period.

Top module: `pbb_halfcycle_pwm`

## Requirements
- R1: While reset is asserted, and afterwards until the first sample has been applied, all five gates are low and the interval code is 00 (idle).
- R2: Inputs are sampled only at the clock edge where the carrier count wraps from PERIOD-1 to 0. A sample takes effect at the following wrap. Input values present at any other edge have no effect on the outputs.
- R3: Gate bit i drives switch i+1 (bit 0 = S1 … bit 4 = S5). In the buck interval (code 01) and the boost interval (code 10), S3 is high and S4 and S5 are low for the whole period.
- R4: A reference with sign 0 and magnitude at most the input selects code 01. S2 stays low and S1 chops with duty floor(mag·65536/vin).
- R5: A reference with sign 0 and magnitude above the input selects code 10. S1 stays high and S2 chops with duty floor((mag−vin)·65536/mag).
- R6: A reference with sign 1 and nonzero magnitude selects code 11. S1, S2 and S3 are low, S5 is high, and S4 chops with duty floor(mag·65536/(mag+vin)).
- R7: The chopping gate is high at carrier counts 0 up to floor(duty·PERIOD/65536)−1 and low for the rest of the period.
- R8: A duty above DUTY_MAX (default 62259, about 0.95) is replaced by DUTY_MAX.
- R9: A reference magnitude of zero, with either sign, selects code 01 with S1 low for the whole period.
- R10: Within a carrier period (any count other than 0), at most one gate line changes per clock, and the interval code does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_neg_i | input | 1 | Sign of the output-voltage reference (1 = negative) |
| ref_mag_i | input | W | Magnitude of the output-voltage reference |
| vin_i | input | W | DC input-voltage measurement |
| gate_o | output | 5 | Gate drives; bit i controls switch i+1 |
| ivl_o | output | 2 | Interval code: 00 idle, 01 buck, 10 boost, 11 negative |

## Verification
The bench builds the block with PERIOD = 32 and keeps W = 16, FW = 16 and the default cap.

The short carrier lets several hundred samples, each on its own period, pass in a short run. Every carrier count of every period is compared against an on-time worked out arithmetically in the bench. The sample set covers:

- both zero references;
- equal reference and input, and a zero input, both of which hit the cap;
- durations that round down to zero;
- the full 16-bit range in all three intervals.

Between wraps, the bench drives deliberately wrong inputs, so the sampling instant is exercised in every period.

// File: rtl/pbb_mod_pkg.sv
package pbb_mod_pkg;

    typedef enum logic [1:0] {
        IVL_IDLE  = 2'b00,
        IVL_BUCK  = 2'b01,
        IVL_BOOST = 2'b10,
        IVL_NEG   = 2'b11
    } ivl_e;

endpackage

// File: rtl/pbb_carrier.sv
module pbb_carrier #(
    parameter int PERIOD = 1000,
    localparam int CW = $clog2(PERIOD)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap_o = (cnt_q == CW'(PERIOD - 1));
        cnt_d  = wrap_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pbb_ratio_div.sv
// Restoring divider for num <= den: quotient = floor(num * 2^FW / den),
// FW+1 bits wide, one bit per clock, FW+1 clocks after start.
module pbb_ratio_div #(
    parameter int NW = 17,
    parameter int FW = 16,
    localparam int IW = $clog2(FW + 2)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic [NW-1:0] num_i,
    input  logic [NW-1:0] den_i,
    output logic          done_o,
    output logic [FW:0]   quo_o
);

    typedef struct packed {
        logic          busy;
        logic          first;
        logic          done;
        logic [IW-1:0] it;
        logic [NW:0]   rem;
        logic [NW-1:0] den;
        logic [FW:0]   quo;
    } div_t;

    div_t st_d, st_q;
    logic [NW:0] trial;
    logic        qbit;

    always_comb begin
        st_d  = st_q;
        st_d.done = 1'b0;
        trial = '0;
        qbit  = 1'b0;
        if (start_i) begin
            st_d.busy  = 1'b1;
            st_d.first = 1'b1;
            st_d.it    = IW'(FW + 1);
            st_d.rem   = {1'b0, num_i};
            st_d.den   = den_i;
            st_d.quo   = '0;
        end else if (st_q.busy) begin
            trial = st_q.first ? st_q.rem : {st_q.rem[NW-1:0], 1'b0};
            if (trial >= {1'b0, st_q.den}) begin
                qbit  = 1'b1;
                trial = trial - {1'b0, st_q.den};
            end
            st_d.rem   = trial;
            st_d.quo   = {st_q.quo[FW-1:0], qbit};
            st_d.first = 1'b0;
            st_d.it    = st_q.it - 1'b1;
            if (st_q.it == IW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.busy  <= 1'b0;
            st_q.first <= 1'b0;
            st_q.done  <= 1'b0;
            st_q.it    <= '0;
            st_q.rem   <= '0;
            st_q.den   <= '0;
            st_q.quo   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign quo_o  = st_q.quo;

endmodule

// File: rtl/pbb_gate_map.sv
module pbb_gate_map
    import pbb_mod_pkg::*;
(
    input  ivl_e       ivl_i,
    input  logic       chop_i,
    output logic [4:0] gate_o
);

    always_comb begin
        case (ivl_i)
            IVL_BUCK:  gate_o = {3'b001, 1'b0, chop_i};
            IVL_BOOST: gate_o = {3'b001, chop_i, 1'b1};
            IVL_NEG:   gate_o = {1'b1, chop_i, 3'b000};
            default:   gate_o = 5'b00000;
        endcase
    end

endmodule

// File: rtl/pbb_halfcycle_pwm.sv
module pbb_halfcycle_pwm
    import pbb_mod_pkg::*;
#(
    parameter int W        = 16,
    parameter int FW       = 16,
    parameter int PERIOD   = 1000,
    parameter int DUTY_MAX = 62259
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         ref_neg_i,
    input  logic [W-1:0] ref_mag_i,
    input  logic [W-1:0] vin_i,
    output logic [4:0]   gate_o,
    output logic [1:0]   ivl_o
);

    localparam int NW = W + 1;
    localparam int CW = $clog2(PERIOD);
    localparam int PW = FW + CW;

    typedef struct packed {
        ivl_e          ivl_pend;
        logic          zero_pend;
        logic [FW-1:0] duty_pend;
        ivl_e          ivl;
        logic [CW-1:0] thr;
    } top_t;

    top_t          st_d, st_q;
    logic [CW-1:0] car_cnt;
    logic          car_wrap;
    logic          div_done;
    logic [FW:0]   div_quo;
    logic [NW-1:0] div_num, div_den;
    ivl_e          smp_ivl;
    logic          smp_zero;
    logic [PW-1:0] on_prod;
    logic          chop;

    pbb_carrier #(.PERIOD(PERIOD)) carrier_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cnt_o (car_cnt),
        .wrap_o(car_wrap)
    );

    // Interval selection and divider operands from the live inputs
    always_comb begin
        smp_zero = (ref_mag_i == '0);
        if (ref_neg_i && !smp_zero)  smp_ivl = IVL_NEG;
        else if (ref_mag_i <= vin_i) smp_ivl = IVL_BUCK;
        else                         smp_ivl = IVL_BOOST;
        case (smp_ivl)
            IVL_BOOST: begin
                div_num = {1'b0, ref_mag_i - vin_i};
                div_den = {1'b0, ref_mag_i};
            end
            IVL_NEG: begin
                div_num = {1'b0, ref_mag_i};
                div_den = {1'b0, ref_mag_i} + {1'b0, vin_i};
            end
            default: begin
                div_num = {1'b0, ref_mag_i};
                div_den = {1'b0, vin_i};
            end
        endcase
    end

    pbb_ratio_div #(.NW(NW), .FW(FW)) div_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .start_i(car_wrap),
        .num_i  (div_num),
        .den_i  (div_den),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    always_comb begin
        st_d    = st_q;
        on_prod = PW'(st_q.duty_pend) * PW'(PERIOD);
        if (div_done) begin
            if (st_q.zero_pend)
                st_d.duty_pend = '0;
            else if (div_quo > (FW + 1)'(DUTY_MAX))
                st_d.duty_pend = FW'(DUTY_MAX);
            else
                st_d.duty_pend = div_quo[FW-1:0];
        end
        if (car_wrap) begin
            st_d.ivl       = st_q.ivl_pend;
            st_d.thr       = CW'(on_prod >> FW);
            st_d.ivl_pend  = smp_ivl;
            st_d.zero_pend = smp_zero;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.ivl_pend  <= IVL_IDLE;
            st_q.zero_pend <= 1'b1;
            st_q.duty_pend <= '0;
            st_q.ivl       <= IVL_IDLE;
            st_q.thr       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chop = (car_cnt < st_q.thr);

    pbb_gate_map map_i (
        .ivl_i (st_q.ivl),
        .chop_i(chop),
        .gate_o(gate_o)
    );

    assign ivl_o = st_q.ivl;

endmodule

// File: rtl/pbb_halfcycle_pwm_chk.sv
module pbb_halfcycle_pwm_chk #(
    parameter int PERIOD = 1000,
    localparam int CW = $clog2(PERIOD)
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic [CW-1:0] cnt_i,
    input logic [4:0]    gate_i,
    input logic [1:0]    ivl_i
);

    AST_IDLE_ALL_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        (ivl_i == 2'b00) |-> (gate_i == 5'b00000)); // R1

    AST_POS_STATIC: assert property (@(posedge clk_i) disable iff (rst_i)
        (ivl_i == 2'b01 || ivl_i == 2'b10) |-> (gate_i[2] && gate_i[4:3] == 2'b00)); // R3

    AST_BUCK_S2_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        (ivl_i == 2'b01) |-> !gate_i[1]); // R4

    AST_BOOST_S1_ON: assert property (@(posedge clk_i) disable iff (rst_i)
        (ivl_i == 2'b10) |-> gate_i[0]); // R5

    AST_NEG_STATIC: assert property (@(posedge clk_i) disable iff (rst_i)
        (ivl_i == 2'b11) |-> (gate_i[2:0] == 3'b000 && gate_i[4])); // R6

    AST_CAP_OFF_AT_END: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_i == CW'(PERIOD - 1)) |->
            !((ivl_i == 2'b01 && gate_i[0]) || (ivl_i == 2'b10 && gate_i[1]) ||
              (ivl_i == 2'b11 && gate_i[3]))); // R8

    AST_SINGLE_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_i != '0) |-> ($countones(gate_i ^ $past(gate_i)) <= 1)); // R10

    AST_IVL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_i != '0) |-> $stable(ivl_i)); // R10

endmodule

bind pbb_halfcycle_pwm pbb_halfcycle_pwm_chk #(.PERIOD(PERIOD)) chk_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .cnt_i (car_cnt),
    .gate_i(gate_o),
    .ivl_i (ivl_o)
);

// File: tb/pbb_halfcycle_pwm_tb_top.sv
`timescale 1ns/1ps
module pbb_halfcycle_pwm_tb_top;

    localparam int P    = 32;
    localparam int DMAX = 62259;
    localparam int NV   = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sgn = 1'b0;
    logic [15:0] mag = '0;
    logic [15:0] vin = '0;
    logic [4:0]  gate;
    logic [1:0]  ivl;

    int checks = 0;
    int fails  = 0;

    bit      vs [NV];
    int      vm [NV];
    int      vv [NV];
    int      e_ivl [NV];
    int      e_thr [NV];
    string   e_tag [NV];

    always #2 clk = ~clk;

    pbb_halfcycle_pwm #(.W(16), .FW(16), .PERIOD(P), .DUTY_MAX(DMAX)) dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .ref_neg_i(sgn),
        .ref_mag_i(mag),
        .vin_i    (vin),
        .gate_o   (gate),
        .ivl_o    (ivl)
    );

    // Reference model of the requirements (R4..R9)
    task automatic model(input bit s, input int m, input int v,
                         output int iv, output int thr, output string tag);
        longint duty;
        if (m == 0) begin
            iv = 1; duty = 0; tag = "R9";
        end else if (!s && m <= v) begin
            iv = 1; duty = (longint'(m) * 65536) / v; tag = "R4";
        end else if (!s) begin
            iv = 2; duty = (longint'(m - v) * 65536) / m; tag = "R5";
        end else begin
            iv = 3; duty = (longint'(m) * 65536) / (m + v); tag = "R6";
        end
        if (duty > DMAX) begin
            duty = DMAX; tag = {tag, " R8"};
        end
        thr = int'((duty * P) >> 16);   // R7 on-time
    endtask

    function automatic logic [4:0] exp_gate(input int iv, input int thr, input int c);
        logic ch;
        ch = (c < thr);
        case (iv)
            1: exp_gate = {4'b0010, ch};        // R3, R4
            2: exp_gate = {3'b001, ch, 1'b1};   // R3, R5
            3: exp_gate = {1'b1, ch, 3'b000};   // R6
            default: exp_gate = 5'b00000;       // R1
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, got hang, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] lcg;
        lcg = 32'h1234_5678;
        // Corner samples, then pseudo-random ones
        for (int k = 0; k < NV; k++) begin
            case (k)
                0:  begin vs[k] = 0; vm[k] = 0;     vv[k] = 1000;  end // R9
                1:  begin vs[k] = 1; vm[k] = 0;     vv[k] = 1000;  end // R9 negative zero
                2:  begin vs[k] = 0; vm[k] = 1000;  vv[k] = 1000;  end // R4 equal, R8
                3:  begin vs[k] = 0; vm[k] = 1001;  vv[k] = 1000;  end // R5 tiny duty
                4:  begin vs[k] = 0; vm[k] = 500;   vv[k] = 1000;  end
                5:  begin vs[k] = 1; vm[k] = 500;   vv[k] = 500;   end
                6:  begin vs[k] = 1; vm[k] = 65535; vv[k] = 65535; end
                7:  begin vs[k] = 0; vm[k] = 65535; vv[k] = 1;     end // R8
                8:  begin vs[k] = 0; vm[k] = 1;     vv[k] = 65535; end
                9:  begin vs[k] = 1; vm[k] = 1;     vv[k] = 0;     end // R8
                10: begin vs[k] = 0; vm[k] = 5;     vv[k] = 0;     end // R8
                11: begin vs[k] = 0; vm[k] = 0;     vv[k] = 0;     end // R9
                12: begin vs[k] = 1; vm[k] = 3000;  vv[k] = 1000;  end
                13: begin vs[k] = 0; vm[k] = 4000;  vv[k] = 1000;  end
                default: begin
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    vs[k] = lcg[31];
                    vm[k] = int'(lcg[15:0]);
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    vv[k] = int'(lcg[15:0] >> lcg[29:28]);
                end
            endcase
            model(vs[k], vm[k], vv[k], e_ivl[k], e_thr[k], e_tag[k]);
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (gate !== 5'b0 || ivl !== 2'b0) begin
            fails++;
            $display("FAIL R1 reset: gate=%b ivl=%0d expected gate=00000 ivl=0", gate, ivl);
        end
        @(negedge clk);
        rst = 1'b0;

        for (int p = 0; p < NV + 2; p++) begin
            bit          bad;
            int          toggles;
            logic [4:0]  prev_g, bad_g, bad_e;
            logic [1:0]  prev_i;
            int          bad_c, bad_iv, iv, thr;
            string       tag;
            bad = 0; toggles = 0; bad_c = 0; bad_g = '0; bad_e = '0; bad_iv = 0;
            prev_g = '0; prev_i = '0;
            if (p < 2) begin iv = 0; thr = 0; tag = "R1"; end
            else begin iv = e_ivl[p-2]; thr = e_thr[p-2]; tag = e_tag[p-2]; end
            for (int c = 0; c < P; c++) begin
                logic [4:0] eg;
                eg = exp_gate(iv, thr, c);
                if (!bad && (gate !== eg || ivl !== 2'(iv))) begin
                    bad = 1; bad_c = c; bad_g = gate; bad_e = eg; bad_iv = int'(ivl);
                end
                if (c > 0 && ($countones(gate ^ prev_g) > 1 || ivl !== prev_i))
                    toggles++;
                prev_g = gate; prev_i = ivl;
                // R2: wrong values between wraps, real sample just before the wrap
                if (c == 0) begin
                    sgn = (p < NV) ? ~vs[p] : 1'b1;
                    mag = (p < NV) ? ~vm[p][15:0] : 16'hFFFF;
                    vin = (p < NV) ? vm[p][15:0] : 16'h0001;
                end else if (c == P - 2) begin
                    sgn = (p < NV) ? vs[p] : 1'b0;
                    mag = (p < NV) ? vm[p][15:0] : '0;
                    vin = (p < NV) ? vv[p][15:0] : '0;
                end
                @(negedge clk);
            end
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL %s (R2 R3 R7) period %0d count %0d: gate=%b ivl=%0d expected gate=%b ivl=%0d",
                         tag, p, bad_c, bad_g, bad_iv, bad_e, iv);
            end
            checks++;
            if (toggles != 0) begin
                fails++;
                $display("FAIL R10 period %0d: %0d multi-edge cycles, expected 0", p, toggles);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule